// File: doc/BRIEF.md
# Precision-time event frame classifier

This block watches received Ethernet frames one byte at a time and decides, for each frame, whether the receive timestamp unit should capture a timestamp for it. It recognises precision-time frames carried directly over Ethernet (by EtherType) and frames carried in IPv4/UDP (by protocol and event port). A selectable policy then narrows the match to version-1 Sync messages, version-1 Delay_Req messages, any version-2 event message, or every frame. When the decision is positive it raises a single-cycle strobe.

The header layout is fixed: an untagged Ethernet header of 14 bytes, and for IP an IPv4 header of exactly 20 bytes followed by an 8-byte UDP header. Policy and filter enables are taken once per frame, on its first byte, so software may change them at any time without corrupting a frame already in flight. Bytes are offered with a valid qualifier and delimited by start-of-frame and end-of-frame markers. Idle cycles inside a frame are allowed.

Top module: `ptp_evt_classifier`

## Requirements
- R1: After reset, and until a frame is offered, the strobe output is low.
- R2: In policy 3 (version-2 events) with the Ethernet-path enable set, a frame whose bytes 12..13 equal 0x88F7 produces a strobe when the low nibble of byte 14 is 0..3, and none otherwise. The upper nibble is ignored.
- R3: A frame qualifies for the UDP path only if bytes 12..13 are 0x0800, byte 14 is 0x45, byte 23 is 17, bytes 36..37 (big-endian) are 319, and the UDP-path enable is set. A mismatch in any of these bytes suppresses the strobe.
- R4: With the source-port check set, bytes 34..35 (big-endian) must also equal 319. With it clear, those bytes are ignored.
- R5: In policy 3, a qualifying UDP frame strobes when the low nibble of byte 42 is 0..3.
- R6: Policy 1 strobes for a qualifying UDP frame whose byte 74 is 0x00. Policy 2 does the same when byte 74 is 0x01. Neither policy ever strobes for an Ethernet-path frame.
- R7: Policy 4 strobes for every frame, regardless of contents or filter enables.
- R8: Policy 0 and the unused codes 5..7 never produce a strobe.
- R9: The strobe is high for exactly one cycle, the cycle after the byte that completes the decision is accepted. That byte is index 0 in policy 4, 14 on the Ethernet path, 42 for version-2 over UDP, and 74 for version 1. There is at most one strobe per frame.
- R10: A frame whose end-of-frame byte comes before its deciding byte produces no strobe.
- R11: Policy, enables and source-port check are sampled with the first byte of the frame. Changes made later in the frame take effect only from the next frame.
- R12: Cycles with valid low are not counted as frame bytes, so idle gaps inside a frame do not shift the field positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame |
| valid_i | input | 1 | Byte on data_i is valid this cycle |
| data_i | input | 8 | Frame byte |
| cfg_mode_i | input | 3 | Policy: 0 off, 1 v1 Sync, 2 v1 Delay_Req, 3 v2 events, 4 all frames |
| cfg_l2_en_i | input | 1 | Enables the EtherType path |
| cfg_l4_en_i | input | 1 | Enables the IPv4/UDP path |
| cfg_sport_chk_i | input | 1 | Also requires the UDP source port to be 319 |
| evt_o | output | 1 | One-cycle timestamp strobe |

## Verification
The bench sweeps every policy code against every combination of the three enables, over frames that differ in one header byte at a time. These include a wrong protocol, port, version/length byte or EtherType, a foreign source port, and message nibbles on both sides of the event range. A design that compared the whole message byte instead of its nibble, or ignored a UDP field, would strobe or stay silent on the wrong variants. Frames cut off exactly one byte before and exactly at the deciding byte test the truncation rule, where an off-by-one counter shows up as a missing strobe or a strobe on a short frame. The index of the strobe is recorded for every frame, so a design that fired a cycle late or twice is caught as well. Policy changes made mid-frame, and idle gaps inserted inside a frame, test the per-frame sampling and that gaps do not count as bytes.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  localparam int IDX_W = 7;
  typedef logic [IDX_W-1:0] idx_t;
  localparam idx_t IDX_MAX = idx_t'((1 << IDX_W) - 1);

  localparam int ETH_HDR_LEN = 14;
  localparam int IP_HDR_LEN  = 20;
  localparam int UDP_HDR_LEN = 8;
  localparam int V1_CTL_POS  = 32;

  localparam idx_t OFF_SOF      = idx_t'(0);
  localparam idx_t OFF_ETYPE_HI = idx_t'(ETH_HDR_LEN - 2);
  localparam idx_t OFF_ETYPE_LO = idx_t'(ETH_HDR_LEN - 1);
  localparam idx_t OFF_L2_PTP   = idx_t'(ETH_HDR_LEN);
  localparam idx_t OFF_IP_VIHL  = idx_t'(ETH_HDR_LEN);
  localparam idx_t OFF_IP_PROTO = idx_t'(ETH_HDR_LEN + 9);
  localparam idx_t OFF_SPORT_HI = idx_t'(ETH_HDR_LEN + IP_HDR_LEN);
  localparam idx_t OFF_SPORT_LO = idx_t'(ETH_HDR_LEN + IP_HDR_LEN + 1);
  localparam idx_t OFF_DPORT_HI = idx_t'(ETH_HDR_LEN + IP_HDR_LEN + 2);
  localparam idx_t OFF_DPORT_LO = idx_t'(ETH_HDR_LEN + IP_HDR_LEN + 3);
  localparam idx_t OFF_L4_PTP   = idx_t'(ETH_HDR_LEN + IP_HDR_LEN + UDP_HDR_LEN);
  localparam idx_t OFF_V1_CTL   = idx_t'(ETH_HDR_LEN + IP_HDR_LEN + UDP_HDR_LEN + V1_CTL_POS);

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_V1_SYNC = 3'd1,
    MODE_V1_DREQ = 3'd2,
    MODE_V2_EVT  = 3'd3,
    MODE_ALL     = 3'd4
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  l2_en;
    logic  l4_en;
    logic  sport_chk;
  } cfg_t;
endpackage

// File: rtl/ptp_cls_byte_idx.sv
module ptp_cls_byte_idx
  import ptp_cls_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic eof_i,
  input  logic valid_i,
  output logic acc_o,
  output idx_t idx_o
);
  logic in_frame_q;
  idx_t cnt_q;

  assign acc_o = valid_i & (sof_i | in_frame_q);
  assign idx_o = sof_i ? OFF_SOF : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
    end else if (acc_o) begin
      in_frame_q <= ~eof_i;
      cnt_q      <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + idx_t'(1);
    end
  end
endmodule

// File: rtl/ptp_cls_hdr_track.sv
module ptp_cls_hdr_track
  import ptp_cls_pkg::*;
#(
  parameter logic [15:0] PTP_ETYPE = 16'h88F7,
  parameter logic [15:0] IP_ETYPE  = 16'h0800,
  parameter logic [7:0]  IP_VIHL   = 8'h45,
  parameter logic [7:0]  UDP_PROTO = 8'd17,
  parameter logic [15:0] EVT_PORT  = 16'd319
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       acc_i,
  input  idx_t       idx_i,
  input  logic [7:0] data_i,
  input  logic       sport_chk_i,
  output logic       l2_ptp_o,
  output logic       l4_ok_o
);
  logic [7:0] et_hi_q, sp_hi_q, dp_hi_q;
  logic is_ptp_q, is_ip_q, vihl_ok_q, proto_ok_q, sp_ok_q, dp_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      et_hi_q    <= '0;
      sp_hi_q    <= '0;
      dp_hi_q    <= '0;
      is_ptp_q   <= 1'b0;
      is_ip_q    <= 1'b0;
      vihl_ok_q  <= 1'b0;
      proto_ok_q <= 1'b0;
      sp_ok_q    <= 1'b0;
      dp_ok_q    <= 1'b0;
    end else if (acc_i) begin
      case (idx_i)
        OFF_SOF: begin
          is_ptp_q   <= 1'b0;
          is_ip_q    <= 1'b0;
          vihl_ok_q  <= 1'b0;
          proto_ok_q <= 1'b0;
          sp_ok_q    <= 1'b0;
          dp_ok_q    <= 1'b0;
        end
        OFF_ETYPE_HI: et_hi_q <= data_i;
        OFF_ETYPE_LO: begin
          is_ptp_q <= ({et_hi_q, data_i} == PTP_ETYPE);
          is_ip_q  <= ({et_hi_q, data_i} == IP_ETYPE);
        end
        OFF_IP_VIHL:  vihl_ok_q  <= (data_i == IP_VIHL);
        OFF_IP_PROTO: proto_ok_q <= (data_i == UDP_PROTO);
        OFF_SPORT_HI: sp_hi_q    <= data_i;
        OFF_SPORT_LO: sp_ok_q    <= ({sp_hi_q, data_i} == EVT_PORT);
        OFF_DPORT_HI: dp_hi_q    <= data_i;
        OFF_DPORT_LO: dp_ok_q    <= ({dp_hi_q, data_i} == EVT_PORT);
        default: ;
      endcase
    end
  end

  assign l2_ptp_o = is_ptp_q;
  assign l4_ok_o  = is_ip_q & vihl_ok_q & proto_ok_q & dp_ok_q & (sp_ok_q | ~sport_chk_i);
endmodule

// File: rtl/ptp_cls_decide.sv
module ptp_cls_decide
  import ptp_cls_pkg::*;
#(
  parameter logic [3:0] V2_EVT_LIMIT = 4'd4,
  parameter logic [7:0] V1_SYNC_CTL  = 8'h00,
  parameter logic [7:0] V1_DREQ_CTL  = 8'h01
) (
  input  logic       acc_i,
  input  idx_t       idx_i,
  input  logic [7:0] data_i,
  input  cfg_t       cfg_i,
  input  logic       l2_ptp_i,
  input  logic       l4_ok_i,
  output logic       hit_o
);
  logic v2_type, l4_path, l2_path;

  assign v2_type = (data_i[3:0] < V2_EVT_LIMIT);
  assign l2_path = cfg_i.l2_en & l2_ptp_i;
  assign l4_path = cfg_i.l4_en & l4_ok_i;

  always_comb begin
    hit_o = 1'b0;
    if (acc_i) begin
      case (cfg_i.mode)
        MODE_ALL:     hit_o = (idx_i == OFF_SOF);
        MODE_V2_EVT:  hit_o = v2_type & (((idx_i == OFF_L2_PTP) & l2_path) |
                                         ((idx_i == OFF_L4_PTP) & l4_path));
        MODE_V1_SYNC: hit_o = (idx_i == OFF_V1_CTL) & l4_path & (data_i == V1_SYNC_CTL);
        MODE_V1_DREQ: hit_o = (idx_i == OFF_V1_CTL) & l4_path & (data_i == V1_DREQ_CTL);
        default:      hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptp_cls_pkg::*;
#(
  parameter logic [15:0] PTP_ETYPE = 16'h88F7,
  parameter logic [15:0] IP_ETYPE  = 16'h0800,
  parameter logic [15:0] EVT_PORT  = 16'd319
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sof_i,
  input  logic       eof_i,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  input  logic [2:0] cfg_mode_i,
  input  logic       cfg_l2_en_i,
  input  logic       cfg_l4_en_i,
  input  logic       cfg_sport_chk_i,
  output logic       evt_o
);
  logic acc, l2_ptp, l4_ok, hit, evt_q;
  idx_t idx;
  cfg_t cfg_live, cfg_q, cfg_eff;

  assign cfg_live = '{mode: mode_e'(cfg_mode_i), l2_en: cfg_l2_en_i,
                      l4_en: cfg_l4_en_i, sport_chk: cfg_sport_chk_i};
  assign cfg_eff  = sof_i ? cfg_live : cfg_q;

  ptp_cls_byte_idx i_idx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sof_i  (sof_i),
    .eof_i  (eof_i),
    .valid_i(valid_i),
    .acc_o  (acc),
    .idx_o  (idx)
  );

  ptp_cls_hdr_track #(
    .PTP_ETYPE(PTP_ETYPE),
    .IP_ETYPE (IP_ETYPE),
    .EVT_PORT (EVT_PORT)
  ) i_hdr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .idx_i      (idx),
    .data_i     (data_i),
    .sport_chk_i(cfg_eff.sport_chk),
    .l2_ptp_o   (l2_ptp),
    .l4_ok_o    (l4_ok)
  );

  ptp_cls_decide i_dec (
    .acc_i   (acc),
    .idx_i   (idx),
    .data_i  (data_i),
    .cfg_i   (cfg_eff),
    .l2_ptp_i(l2_ptp),
    .l4_ok_i (l4_ok),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '{mode: MODE_OFF, l2_en: 1'b0, l4_en: 1'b0, sport_chk: 1'b0};
      evt_q <= 1'b0;
    end else begin
      if (acc && sof_i) cfg_q <= cfg_live;
      evt_q <= hit;
    end
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/ptp_cls_checker.sv
module ptp_cls_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sof_i,
  input logic       valid_i,
  input logic [7:0] data_i,
  input logic [2:0] cfg_mode_i,
  input logic       evt_o
);
  logic       seen_q;
  logic [2:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      cap_q  <= 3'd0;
    end else if (valid_i && sof_i) begin
      seen_q <= 1'b0;
      cap_q  <= cfg_mode_i;
    end else if (evt_o) begin
      seen_q <= 1'b1;
    end
  end

  p_one_per_frame_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> !seen_q);

  p_after_byte_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(valid_i));

  p_mode_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (cap_q inside {3'd1, 3'd2, 3'd3, 3'd4}));

  p_all_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sof_i && cfg_mode_i == 3'd4) |=> evt_o);

  p_sync_ctl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && cap_q == 3'd1) |-> ($past(data_i) == 8'h00));

  p_dreq_ctl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && cap_q == 3'd2) |-> ($past(data_i) == 8'h01));

  p_v2_type_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && cap_q == 3'd3) |-> ($past(data_i[3:0]) < 4'd4));
endmodule

bind ptp_evt_classifier ptp_cls_checker i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sof_i     (sof_i),
  .valid_i   (valid_i),
  .data_i    (data_i),
  .cfg_mode_i(cfg_mode_i),
  .evt_o     (evt_o)
);

// File: tb/test_ptp_evt_classifier.sv
module test_ptp_evt_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int FMAX = 80;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sof = 1'b0, eof = 1'b0, valid = 1'b0;
  logic [7:0] data = 8'h00;
  logic [2:0] mode = 3'd0;
  logic l2_en = 1'b0, l4_en = 1'b0, schk = 1'b0;
  logic evt;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int hits, hit_idx;

  logic [7:0] fb [FMAX];
  logic [15:0] f_etype, f_sp, f_dp;
  logic [7:0] f_vihl, f_proto, f_msg, f_ctl;
  int f_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_evt_classifier i_ptp_evt_classifier (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof), .eof_i(eof), .valid_i(valid),
    .data_i(data), .cfg_mode_i(mode), .cfg_l2_en_i(l2_en), .cfg_l4_en_i(l4_en),
    .cfg_sport_chk_i(schk), .evt_o(evt)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic build(input int kind, input int v);
    logic [7:0] msgs [4] = '{8'h10, 8'h13, 8'h04, 8'h0B};
    f_etype = 16'h0800; f_vihl = 8'h45; f_proto = 8'd17;
    f_sp = 16'd319; f_dp = 16'd319; f_msg = msgs[v]; f_ctl = 8'(v); f_len = FMAX;
    case (kind)
      0: begin f_etype = 16'h88F7; f_len = 20; end
      1: begin f_etype = 16'h88F7; f_len = 14; end
      3: f_len = 43;
      4: f_len = 42;
      5: f_len = 74;
      6: case (v)
           0: f_proto = 8'd6;
           1: f_dp = 16'd320;
           2: f_vihl = 8'h46;
           default: f_etype = 16'h0806;
         endcase
      7: f_sp = 16'd320;
      default: ;
    endcase
    for (int i = 0; i < FMAX; i++) fb[i] = 8'(i * 7 + 3);
    fb[12] = f_etype[15:8]; fb[13] = f_etype[7:0];
    if (f_etype == 16'h88F7) fb[14] = f_msg;
    else begin
      fb[14] = f_vihl; fb[23] = f_proto;
      fb[34] = f_sp[15:8]; fb[35] = f_sp[7:0];
      fb[36] = f_dp[15:8]; fb[37] = f_dp[7:0];
      fb[42] = f_msg; fb[74] = f_ctl;
    end
  endtask

  // expected strobe index from the requirements, -1 for none
  function automatic int expect_idx(input logic [2:0] m, input bit e2, input bit e4, input bit sc);
    bit l2ok, ipok;
    l2ok = (f_etype == 16'h88F7) && e2;
    ipok = (f_etype == 16'h0800) && (f_vihl == 8'h45) && (f_proto == 8'd17) &&
           (f_dp == 16'd319) && (!sc || f_sp == 16'd319) && e4;
    case (m)
      3'd4: return 0;
      3'd3: begin
        if (l2ok && f_len > 14 && f_msg[3:0] < 4) return 14;
        if (ipok && f_len > 42 && f_msg[3:0] < 4) return 42;
        return -1;
      end
      3'd1: return (ipok && f_len > 74 && f_ctl == 8'h00) ? 74 : -1;
      3'd2: return (ipok && f_len > 74 && f_ctl == 8'h01) ? 74 : -1;
      default: return -1;
    endcase
  endfunction

  task automatic smp(input int prev);
    if (evt) begin hits++; hit_idx = prev; end
  endtask

  task automatic send(input bit gaps, input int chg_at, input logic [2:0] chg_mode);
    int prev = -1;
    hits = 0; hit_idx = -1;
    for (int i = 0; i < f_len; i++) begin
      if (gaps && (i % 3 == 2)) begin
        @(negedge clk); smp(prev);
        valid = 1'b0; sof = 1'b0; eof = 1'b0; data = 8'h45;
      end
      @(negedge clk); smp(prev);
      sof = (i == 0); valid = 1'b1; data = fb[i]; eof = (i == f_len - 1);
      if (i == chg_at) mode = chg_mode;
      prev = i;
    end
    for (int g = 0; g < 4; g++) begin
      @(negedge clk); smp(prev);
      valid = 1'b0; sof = 1'b0; eof = 1'b0;
    end
  endtask

  function automatic string tag(input int m, input int kind);
    if (m == 0 || m > 4) return "R8";
    if (m == 4) return "R7";
    if (kind == 1 || kind == 3 || kind == 4 || kind == 5) return "R10";
    if (kind == 7) return "R4";
    if (kind == 6) return "R3";
    if (m == 3 && kind == 0) return "R2";
    if (m == 3) return "R5";
    return "R6";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int e;
    repeat (3) @(negedge clk);
    chk(evt === 1'b0, "R1", "strobe in reset", int'(evt), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(evt === 1'b0, "R1", "strobe after reset", int'(evt), 0);

    for (int mi = 0; mi < 6; mi++) begin
      for (int c = 0; c < 8; c++) begin
        for (int kind = 0; kind < 8; kind++) begin
          for (int v = 0; v < 4; v++) begin
            mode = (mi == 5) ? 3'd6 : 3'(mi);
            l2_en = c[0]; l4_en = c[1]; schk = c[2];
            build(kind, v);
            e = expect_idx(mode, l2_en, l4_en, schk);
            send(1'b0, -1, 3'd0);
            chk(hits == ((e >= 0) ? 1 : 0), tag(mi, kind), "strobe count", hits, (e >= 0) ? 1 : 0);
            chk(hit_idx == e, "R9", "strobe byte index", hit_idx, e);
          end
        end
      end
    end

    // R11: policy changed after the first byte is not used for this frame
    l2_en = 1'b0; l4_en = 1'b1; schk = 1'b1;
    build(2, 1); mode = 3'd3;
    send(1'b0, 20, 3'd0);
    chk(hit_idx == 42, "R11", "late switch to off", hit_idx, 42);
    build(2, 2); mode = 3'd0;
    send(1'b0, 5, 3'd4);
    chk(hits == 0, "R11", "late switch to all", hits, 0);
    build(6, 0);
    send(1'b0, -1, 3'd0);
    chk(hits == 1 && hit_idx == 0, "R11", "switch applies next frame", hit_idx, 0);

    // R12: idle gaps inside frames
    mode = 3'd1; build(2, 0);
    send(1'b1, -1, 3'd0);
    chk(hits == 1 && hit_idx == 74, "R12", "v1 sync with gaps", hit_idx, 74);
    mode = 3'd3; l2_en = 1'b1; build(0, 3);
    send(1'b1, -1, 3'd0);
    chk(hits == 0, "R12", "l2 non-event with gaps", hits, 0);
    build(0, 1);
    send(1'b1, -1, 3'd0);
    chk(hits == 1 && hit_idx == 14, "R12", "l2 event with gaps", hit_idx, 14);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule